// File: doc/BRIEF.md
# Dual Page Buffer Access Unit

This unit holds two independent 528-byte page buffers. It sits between a serial command front-end and a page-wide array engine. The front-end opens a buffer session by naming a buffer, a direction and a 10-bit starting byte address. After that it either shifts write data in one bit at a time or asks for read bytes one at a time. A single pointer steps through the buffer and wraps from the last byte back to byte 0.

The array engine reaches the same storage through a parallel port. It can write or read any byte of either buffer, one byte per cycle. Each buffer has a single storage port. When the parallel port and the serial side want the same buffer in the same cycle, the parallel port wins. The serial side then waits: a finished write byte is held until the buffer is free, and a read request is refused. Serial work on the other buffer goes ahead in that cycle.

Top module: `dual_page_buf`

## Requirements
- R1: After reset, `s_rd_valid_o` and `p_rvalid_o` are low and no serial session is open.
- R2: A parallel request with `p_we_i`=1 writes `p_wdata_i` at `p_addr_i` of the buffer chosen by `p_sel_i` (0 = first buffer, 1 = second buffer). With `p_we_i`=0, `p_rdata_o` holds the addressed byte and `p_rvalid_o` is high in the cycle after the request. The two buffers do not affect each other.
- R3: In a write session (`s_wr_i`=1 at start), each group of eight `s_bit_i` samples taken while `s_bit_vld_i` is high forms one byte, most significant bit first. That byte is stored at the pointer, and the pointer then advances by one.
- R4: The serial pointer steps from byte 527 to byte 0 of the same buffer, in both write and read sessions.
- R5: A starting address from 528 to 1023 is reduced by 528 before it is used. For example, 1000 selects byte 472.
- R6: A pulse on `s_end_i` closes the session. Fewer than eight collected bits are thrown away and nothing is written. The next session starts with an empty bit count.
- R7: In a read session, a `s_rd_req_i` pulse returns the byte at the pointer on `s_rd_data_o`, with `s_rd_valid_o` high in the next cycle, and the pointer advances by one. Reading does not change the contents of either buffer.
- R8: When a parallel request targets the buffer of a serial read request in the same cycle, the parallel request is served. The serial request is dropped: `s_rd_valid_o` stays low and the pointer does not move. A serial read on the other buffer is served in that same cycle.
- R9: A completed write byte that meets a parallel request on its buffer is held, unchanged, until the first cycle the buffer is free. It is then written, even if the session has closed in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_start_i | input | 1 | Opens a serial session |
| s_wr_i | input | 1 | Session direction at start: 1 = write, 0 = read |
| s_sel_i | input | 1 | Session buffer at start |
| s_addr_i | input | 10 | Starting byte address at start |
| s_end_i | input | 1 | Closes the session (chip select released) |
| s_bit_vld_i | input | 1 | A write data bit is present |
| s_bit_i | input | 1 | Write data bit, MSB first |
| s_rd_req_i | input | 1 | Requests the next read byte |
| s_rd_data_o | output | 8 | Serial read byte |
| s_rd_valid_o | output | 1 | `s_rd_data_o` holds a new byte |
| p_en_i | input | 1 | Parallel access request |
| p_we_i | input | 1 | Parallel write when 1, read when 0 |
| p_sel_i | input | 1 | Parallel buffer select |
| p_addr_i | input | 10 | Parallel byte address, 0 to 527 |
| p_wdata_i | input | 8 | Parallel write byte |
| p_rdata_o | output | 8 | Parallel read byte |
| p_rvalid_o | output | 1 | `p_rdata_o` holds the requested byte |

## Verification
A parallel read issued at one edge shows its data after that same edge, and the bench samples it at the following falling edge. A serial read request follows the same timing, so a dropped request shows up as `s_rd_valid_o` being low at exactly that sample. A serial write byte completes on the edge of its eighth bit and reaches storage one edge later, or later still if it is blocked. The bench therefore leaves at least one free cycle before it reads a written byte back through the parallel port. In the blocking test it reads the same byte while the write is held and expects the old value.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } ser_mode_e;

  typedef struct packed {
    logic       en;
    logic       we;
    logic [9:0] addr;
    logic [7:0] wdata;
  } buf_req_t;
endpackage

// File: rtl/dpb_ram.sv
module dpb_ram #(
  parameter int DEPTH = 528,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = (32'(addr_i) < DEPTH);

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        if (in_range) mem[addr_i] <= wdata_i;
      end else begin
        rdata_o <= in_range ? mem[addr_i] : '0;
      end
    end
  end
endmodule

// File: rtl/dpb_ser_ctl.sv
module dpb_ser_ctl #(
  parameter int DEPTH = 528,
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter int SW    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          end_i,
  input  logic          bit_vld_i,
  input  logic          bit_i,
  input  logic          rd_req_i,
  input  logic          grant_i,
  output logic          acc_o,
  output logic          acc_we_o,
  output logic [SW-1:0] tgt_sel_o,
  output logic [AW-1:0] acc_addr_o,
  output logic [DW-1:0] acc_wdata_o,
  output logic          rd_go_o
);
  import dpb_pkg::*;

  localparam int CW = $clog2(DW);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SPAN = AW'(DEPTH);

  logic          active_q;
  ser_mode_e     mode_q;
  logic [SW-1:0] sel_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-2:0] sh_q;
  logic          pend_q;
  logic [DW-1:0] pend_byte_q;
  logic [AW-1:0] pend_addr_q;
  logic [SW-1:0] pend_sel_q;

  logic byte_done, rd_want, pend_go;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // starts beyond the buffer fold back by one buffer length
  function automatic logic [AW-1:0] start_fold(input logic [AW-1:0] a);
    return (a >= SPAN) ? a - SPAN : a;
  endfunction

  assign byte_done = active_q && (mode_q == MODE_WR) && bit_vld_i && (cnt_q == CW'(DW - 1));
  assign rd_want   = active_q && (mode_q == MODE_RD) && rd_req_i && !pend_q;
  assign pend_go   = pend_q && grant_i;

  assign acc_o       = pend_q || rd_want;
  assign acc_we_o    = pend_q;
  assign tgt_sel_o   = pend_q ? pend_sel_q : sel_q;
  assign acc_addr_o  = pend_q ? pend_addr_q : ptr_q;
  assign acc_wdata_o = pend_byte_q;
  assign rd_go_o     = rd_want && grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      mode_q      <= MODE_RD;
      sel_q       <= '0;
      ptr_q       <= '0;
      cnt_q       <= '0;
      sh_q        <= '0;
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
      pend_addr_q <= '0;
      pend_sel_q  <= '0;
    end else begin
      if (pend_go) pend_q <= 1'b0;
      if (active_q && (mode_q == MODE_WR) && bit_vld_i) begin
        sh_q  <= {sh_q[DW-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (byte_done) begin
        cnt_q       <= '0;
        pend_q      <= 1'b1;
        pend_byte_q <= {sh_q, bit_i};
        pend_addr_q <= ptr_q;
        pend_sel_q  <= sel_q;
        ptr_q       <= ptr_inc(ptr_q);
      end
      if (rd_go_o) ptr_q <= ptr_inc(ptr_q);
      if (end_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end
      if (start_i) begin
        active_q <= 1'b1;
        mode_q   <= wr_i ? MODE_WR : MODE_RD;
        sel_q    <= sel_i;
        ptr_q    <= start_fold(addr_i);
        cnt_q    <= '0;
      end
    end
  end

  a_r4_ptr_in_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < DEPTH);

  a_r6_end_drops_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !start_i |=> !active_q && cnt_q == '0);

  a_r9_held_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !grant_i && !byte_done |=> pend_q && $stable(pend_byte_q) && $stable(pend_addr_q));
endmodule

// File: rtl/dual_page_buf.sv
module dual_page_buf #(
  parameter int BUF_BYTES = 528,
  parameter int NUM_BUFS  = 2,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_start_i,
  input  logic              s_wr_i,
  input  logic              s_sel_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic              s_end_i,
  input  logic              s_bit_vld_i,
  input  logic              s_bit_i,
  input  logic              s_rd_req_i,
  output logic [DATA_W-1:0] s_rd_data_o,
  output logic              s_rd_valid_o,
  input  logic              p_en_i,
  input  logic              p_we_i,
  input  logic              p_sel_i,
  input  logic [ADDR_W-1:0] p_addr_i,
  input  logic [DATA_W-1:0] p_wdata_i,
  output logic [DATA_W-1:0] p_rdata_o,
  output logic              p_rvalid_o
);
  localparam int SEL_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;

  logic              s_acc, s_acc_we, s_grant, s_rd_go;
  logic [SEL_W-1:0]  s_tgt;
  logic [ADDR_W-1:0] s_acc_addr;
  logic [DATA_W-1:0] s_acc_wdata;
  logic [DATA_W-1:0] buf_q [NUM_BUFS];
  logic [SEL_W-1:0]  p_sel_q, s_sel_q;

  assign s_grant = !(p_en_i && (SEL_W'(p_sel_i) == s_tgt));

  dpb_ser_ctl #(
    .DEPTH(BUF_BYTES), .AW(ADDR_W), .DW(DATA_W), .SW(SEL_W)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (s_start_i),
    .wr_i       (s_wr_i),
    .sel_i      (SEL_W'(s_sel_i)),
    .addr_i     (s_addr_i),
    .end_i      (s_end_i),
    .bit_vld_i  (s_bit_vld_i),
    .bit_i      (s_bit_i),
    .rd_req_i   (s_rd_req_i),
    .grant_i    (s_grant),
    .acc_o      (s_acc),
    .acc_we_o   (s_acc_we),
    .tgt_sel_o  (s_tgt),
    .acc_addr_o (s_acc_addr),
    .acc_wdata_o(s_acc_wdata),
    .rd_go_o    (s_rd_go)
  );

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic p_hit, s_hit;
    dpb_pkg::buf_req_t req;

    assign p_hit = p_en_i && (SEL_W'(p_sel_i) == SEL_W'(b));
    assign s_hit = s_acc && s_grant && (s_tgt == SEL_W'(b));

    always_comb begin
      if (p_hit) begin
        req = '{en: 1'b1, we: p_we_i, addr: p_addr_i, wdata: p_wdata_i};
      end else begin
        req = '{en: s_hit, we: s_acc_we, addr: s_acc_addr, wdata: s_acc_wdata};
      end
    end

    dpb_ram #(.DEPTH(BUF_BYTES), .AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk_i  (clk_i),
      .en_i   (req.en),
      .we_i   (req.we),
      .addr_i (req.addr),
      .wdata_i(req.wdata),
      .rdata_o(buf_q[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_rvalid_o   <= 1'b0;
      s_rd_valid_o <= 1'b0;
      p_sel_q      <= '0;
      s_sel_q      <= '0;
    end else begin
      p_rvalid_o   <= p_en_i && !p_we_i;
      s_rd_valid_o <= s_rd_go;
      if (p_en_i) p_sel_q <= SEL_W'(p_sel_i);
      if (s_rd_go) s_sel_q <= s_tgt;
    end
  end

  assign p_rdata_o   = buf_q[p_sel_q];
  assign s_rd_data_o = buf_q[s_sel_q];

  a_r2_par_read_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_en_i && !p_we_i |=> p_rvalid_o);

  a_r7_ser_read_asked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rd_valid_o |-> $past(s_rd_req_i));

  a_r8_par_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_en_i && s_acc && (s_tgt == SEL_W'(p_sel_i)) |=> !s_rd_valid_o);
endmodule

// File: tb/tb_dual_page_buf.sv
`timescale 1ns/1ps
module tb_dual_page_buf;
  localparam int NB = 528;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       s_start_i = 0, s_wr_i = 0, s_sel_i = 0, s_end_i = 0;
  logic       s_bit_vld_i = 0, s_bit_i = 0, s_rd_req_i = 0;
  logic [9:0] s_addr_i = '0;
  logic [7:0] s_rd_data_o;
  logic       s_rd_valid_o;
  logic       p_en_i = 0, p_we_i = 0, p_sel_i = 0;
  logic [9:0] p_addr_i = '0;
  logic [7:0] p_wdata_i = '0;
  logic [7:0] p_rdata_o;
  logic       p_rvalid_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [2][NB];
  int ptr_m;

  always #2 clk_i = ~clk_i;

  dual_page_buf dut (.*);

  function automatic int fold(input int a);
    return (a >= NB) ? a - NB : a;
  endfunction

  function automatic int step(input int p);
    return (p == NB - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic par_wr(input bit sel, input int a, input logic [7:0] d);
    p_en_i = 1; p_we_i = 1; p_sel_i = sel; p_addr_i = 10'(a); p_wdata_i = d;
    @(negedge clk_i);
    p_en_i = 0; p_we_i = 0;
    mdl[sel][a] = d;
  endtask

  task automatic par_rd(input bit sel, input int a, input string req);
    p_en_i = 1; p_we_i = 0; p_sel_i = sel; p_addr_i = 10'(a);
    @(negedge clk_i);
    chk(p_rvalid_o === 1'b1, req, int'(p_rvalid_o), 1);
    chk(p_rdata_o === mdl[sel][a], req, int'(p_rdata_o), int'(mdl[sel][a]));
    p_en_i = 0;
  endtask

  task automatic ser_open(input bit sel, input bit wr, input int a);
    s_start_i = 1; s_sel_i = sel; s_wr_i = wr; s_addr_i = 10'(a);
    @(negedge clk_i);
    s_start_i = 0;
    ptr_m = fold(a);
  endtask

  task automatic ser_close();
    s_end_i = 1;
    @(negedge clk_i);
    s_end_i = 0;
  endtask

  task automatic ser_byte(input bit sel, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      s_bit_vld_i = 1; s_bit_i = d[i];
      @(negedge clk_i);
    end
    s_bit_vld_i = 0;
    mdl[sel][ptr_m] = d;
    ptr_m = step(ptr_m);
  endtask

  task automatic ser_rd(input bit sel, input string req);
    s_rd_req_i = 1;
    @(negedge clk_i);
    s_rd_req_i = 0;
    chk(s_rd_valid_o === 1'b1, req, int'(s_rd_valid_o), 1);
    chk(s_rd_data_o === mdl[sel][ptr_m], req, int'(s_rd_data_o), int'(mdl[sel][ptr_m]));
    ptr_m = step(ptr_m);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk_i);
    // R1 reset state
    chk(s_rd_valid_o === 1'b0, "R1", int'(s_rd_valid_o), 0);
    chk(p_rvalid_o === 1'b0, "R1", int'(p_rvalid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    s_rd_req_i = 1;  // no session open: must be ignored
    @(negedge clk_i);
    s_rd_req_i = 0;
    chk(s_rd_valid_o === 1'b0, "R1", int'(s_rd_valid_o), 0);

    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NB; a++) par_wr(b[0], a, 8'($urandom));

    // R2 independence of buffers
    par_wr(0, 100, 8'h3C);
    par_wr(1, 100, 8'hC3);
    par_rd(0, 100, "R2");
    par_rd(1, 100, "R2");

    // R3 serial write, MSB first
    ser_open(0, 1, 10);
    ser_byte(0, 8'hA5);
    ser_byte(0, 8'h01);
    ser_close();
    par_rd(0, 10, "R3");
    par_rd(0, 11, "R3");

    // R4 wrap on write and read
    ser_open(1, 1, 526);
    ser_byte(1, 8'h11);
    ser_byte(1, 8'h22);
    ser_byte(1, 8'h33);
    ser_close();
    par_rd(1, 0, "R4");
    ser_open(1, 0, 527);
    ser_rd(1, "R4");
    ser_rd(1, "R4");
    ser_close();

    // R5 start address folding: 1000 -> 472
    ser_open(0, 1, 1000);
    chk(ptr_m == 472, "R5", ptr_m, 472);
    ser_byte(0, 8'h5A);
    ser_close();
    par_rd(0, 472, "R5");

    // R6 partial byte discarded
    ser_open(0, 1, 300);
    for (int i = 0; i < 5; i++) begin
      s_bit_vld_i = 1; s_bit_i = 1'(i);
      @(negedge clk_i);
    end
    s_bit_vld_i = 0;
    ser_close();
    @(negedge clk_i);
    par_rd(0, 300, "R6");
    ser_open(0, 1, 300);
    ser_byte(0, 8'h81);
    ser_close();
    par_rd(0, 300, "R6");

    // R7 serial read stream, contents unchanged
    ser_open(0, 0, 10);
    ser_rd(0, "R7");
    ser_rd(0, "R7");
    ser_close();
    par_rd(0, 10, "R7");

    // R8 parallel wins on same buffer, other buffer proceeds
    ser_open(1, 0, 50);
    s_rd_req_i = 1; p_en_i = 1; p_we_i = 0; p_sel_i = 1; p_addr_i = 10'd60;
    @(negedge clk_i);
    s_rd_req_i = 0; p_en_i = 0;
    chk(s_rd_valid_o === 1'b0, "R8", int'(s_rd_valid_o), 0);
    chk(p_rdata_o === mdl[1][60], "R8", int'(p_rdata_o), int'(mdl[1][60]));
    ser_rd(1, "R8");
    s_rd_req_i = 1; p_en_i = 1; p_we_i = 0; p_sel_i = 0; p_addr_i = 10'd60;
    @(negedge clk_i);
    s_rd_req_i = 0; p_en_i = 0;
    chk(s_rd_valid_o === 1'b1, "R8", int'(s_rd_valid_o), 1);
    chk(s_rd_data_o === mdl[1][51], "R8", int'(s_rd_data_o), int'(mdl[1][51]));
    chk(p_rdata_o === mdl[0][60], "R8", int'(p_rdata_o), int'(mdl[0][60]));
    ser_close();

    // R9 completed byte held while buffer busy
    ser_open(0, 1, 200);
    for (int i = 7; i >= 1; i--) begin
      s_bit_vld_i = 1; s_bit_i = 1'(8'hE7 >> i);
      @(negedge clk_i);
    end
    s_bit_vld_i = 1; s_bit_i = 1'b1;
    p_en_i = 1; p_we_i = 0; p_sel_i = 0; p_addr_i = 10'd200;
    @(negedge clk_i);
    s_bit_vld_i = 0;
    chk(p_rdata_o === mdl[0][200], "R9", int'(p_rdata_o), int'(mdl[0][200]));
    s_end_i = 1;
    @(negedge clk_i);
    s_end_i = 0;
    chk(p_rdata_o === mdl[0][200], "R9", int'(p_rdata_o), int'(mdl[0][200]));
    p_en_i = 0;
    @(negedge clk_i);
    mdl[0][200] = 8'hE7;
    par_rd(0, 200, "R9");

    // random sessions mixed with parallel reads
    for (int it = 0; it < 50; it++) begin
      bit sel;
      int n;
      sel = 1'($urandom);
      n = 1 + int'($urandom % 12);
      ser_open(sel, 1, int'($urandom % 1024));
      for (int k = 0; k < n; k++) ser_byte(sel, 8'($urandom));
      ser_close();
      n = 1 + int'($urandom % 12);
      ser_open(sel, 0, int'($urandom % 1024));
      for (int k = 0; k < n; k++) ser_rd(sel, "R7");
      ser_close();
      par_rd(1'($urandom), int'($urandom % NB), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule